// File: doc/BRIEF.md
# Character-Cell Text Video Generator

This block turns a text screen into a monochrome pixel stream for a 256 × 192 visible raster. The screen is a grid of character cells, each 8 pixels wide and 12 scan lines tall, which gives 32 columns by 16 rows (512 positions). For every cell the block reads a character code from an external screen memory. It combines that code with the scan line inside the cell to address an external glyph pattern ROM, and shifts the returned 8-bit slice out one pixel per beat. Any glyph may appear in any cell.

The output is a valid/ready stream with one beat per raster position, blanking included. Each beat carries the pixel, an active-area flag and both sync flags. The sink may hold `pix_ready` low for any number of cycles. While it does, the current beat is held unchanged, the whole raster freezes and nothing is dropped. Both memories are read synchronously with one clock of latency. The cell height of 12 is not a power of two, so the scan line is split into cell row and glyph line by counters kept in step with the raster, not by taking bits.

Top module: `text_cell_video`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `pix_valid`, `pix_data` and `pix_active` are low. The first beat offered after reset is column 0 of line V_TOTAL-1 (261 by default), which lies in blanking.
- R2: Each accepted beat (valid and ready at a rising edge) advances the column by one. After column H_TOTAL-1 (319) the column wraps to 0 and the line advances. After line V_TOTAL-1 the line wraps to 0.
- R3: `pix_active` is high exactly when column < 256 and line < 192. `pix_data` is 0 whenever `pix_active` is low.
- R4: The screen memory address for a visible pixel is (line div 12) × 32 + (column div 8), 9 bits wide.
- R5: The glyph ROM address is code × 16 + (line mod 12). The 7-bit code occupies bits [10:4] and the glyph line occupies bits [3:0], so bits [3:0] never exceed 11.
- R6: A visible pixel equals bit 7 − (column mod 8) of the glyph slice, so the most significant bit appears first.
- R7: Both memories return data one clock after the address is presented. The screen and glyph addresses change only at an accepted beat, and the screen address changes at most once per 8 accepted beats.
- R8: After reset `pix_valid` stays high. While `pix_ready` is low, every output field of the current beat holds its value, and no raster position is skipped.
- R9: `pix_hsync` is high for columns 272 to 295 and `pix_vsync` is high for lines 216 to 218. Both ranges are set by parameters.
- R10: After a frame wrap, line 0 again maps to cell row 0 and glyph line 0, and the second frame reproduces the same picture as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_ready | input | 1 | Sink accepts the current beat |
| pix_valid | output | 1 | A beat is offered |
| pix_data | output | 1 | Pixel value, 1 = lit |
| pix_active | output | 1 | Beat lies in the visible area |
| pix_hsync | output | 1 | Horizontal sync flag of the beat |
| pix_vsync | output | 1 | Vertical sync flag of the beat |
| scr_addr | output | 9 | Screen memory read address |
| scr_code | input | 7 | Character code, one clock after scr_addr |
| gly_addr | output | 11 | Glyph ROM read address |
| gly_data | input | 8 | Glyph slice, one clock after gly_addr |

## Verification
The hardest case to reach is back-pressure that lands between a fetch and its use: `pix_ready` falls just after the screen address moves or just before the glyph slice is loaded, while the synchronous memories keep re-reading the held addresses. The stimulus sweeps more than a full frame. It starts with an always-ready stretch, then random single-cycle stalls at every cell phase, then a long stall placed in the middle of a visible line, and ends with a regular two-of-three ready pattern across the frame wrap. Every beat is compared against a model that computes cell row and glyph line by division.

// File: rtl/vt_pkg.sv
`timescale 1ns/1ps
package vt_pkg;
  // Sideband flags that travel with each pixel beat.
  typedef struct packed {
    logic act;
    logic hs;
    logic vs;
  } vt_flags_t;
endpackage

// File: rtl/vt_raster.sv
`timescale 1ns/1ps
// Raster position counters with an incrementally kept cell row and glyph line.
module vt_raster #(
  parameter int H_TOTAL = 320,
  parameter int V_TOTAL = 262,
  parameter int CELL_H  = 12,
  parameter int HW      = 9,
  parameter int VW      = 9,
  parameter int RW      = 5,
  parameter int LW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [HW-1:0] h,
  output logic [VW-1:0] v,
  output logic [HW-1:0] nxt_h,
  output logic [VW-1:0] nxt_v,
  output logic [RW-1:0] nxt_crow,
  output logic [LW-1:0] nxt_cline,
  output logic [VW-1:0] fol_v,
  output logic [RW-1:0] fol_crow,
  output logic [LW-1:0] fol_cline
);
  localparam int SW = VW + RW + LW;

  logic [RW-1:0] crow;
  logic [LW-1:0] cline;
  logic          line_end;

  // One line forward: the glyph line wraps at CELL_H-1 and bumps the cell row.
  function automatic logic [SW-1:0] line_step(input logic [VW-1:0] vi,
                                              input logic [RW-1:0] ri,
                                              input logic [LW-1:0] li);
    if (vi == VW'(V_TOTAL-1))
      return '0;
    else if (li == LW'(CELL_H-1))
      return {vi + VW'(1), ri + RW'(1), LW'(0)};
    else
      return {vi + VW'(1), ri, li + LW'(1)};
  endfunction

  always_comb begin
    line_end = (h == HW'(H_TOTAL-1));
    nxt_h    = line_end ? '0 : h + HW'(1);
    if (line_end)
      {nxt_v, nxt_crow, nxt_cline} = line_step(v, crow, cline);
    else
      {nxt_v, nxt_crow, nxt_cline} = {v, crow, cline};
    {fol_v, fol_crow, fol_cline} = line_step(nxt_v, nxt_crow, nxt_cline);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h     <= '0;
      v     <= VW'(V_TOTAL-1);
      crow  <= RW'((V_TOTAL-1) / CELL_H);
      cline <= LW'((V_TOTAL-1) % CELL_H);
    end else if (adv) begin
      h     <= nxt_h;
      v     <= nxt_v;
      crow  <= nxt_crow;
      cline <= nxt_cline;
    end
  end
endmodule

// File: rtl/vt_fetch.sv
`timescale 1ns/1ps
// Issues the screen read at the start of a cell for the following cell, then the
// glyph read half a cell later. Both addresses stay put between updates, so a
// stall never disturbs data still in flight from the synchronous memories.
module vt_fetch #(
  parameter int ACT_W   = 256,
  parameter int ACT_H   = 192,
  parameter int CELL_W  = 8,
  parameter int H_TOTAL = 320,
  parameter int HW      = 9,
  parameter int VW      = 9,
  parameter int RW      = 5,
  parameter int LW      = 4,
  parameter int CODE_W  = 7,
  parameter int SCR_AW  = 9,
  parameter int COLS    = 32,
  parameter int COLW    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adv,
  input  logic [HW-1:0]        nxt_h,
  input  logic [VW-1:0]        nxt_v,
  input  logic [RW-1:0]        nxt_crow,
  input  logic [LW-1:0]        nxt_cline,
  input  logic [VW-1:0]        fol_v,
  input  logic [RW-1:0]        fol_crow,
  input  logic [LW-1:0]        fol_cline,
  input  logic [CODE_W-1:0]    scr_code,
  output logic [SCR_AW-1:0]    scr_addr,
  output logic [CODE_W+LW-1:0] gly_addr
);
  localparam int CWL = $clog2(CELL_W);

  logic [CWL-1:0]  phase;
  logic            in_line, wrap;
  logic [VW-1:0]   tgt_v;
  logic [RW-1:0]   tgt_crow;
  logic [LW-1:0]   tgt_cline;
  logic [COLW-1:0] tgt_col;
  logic            tgt_act;
  logic            t_ok;
  logic [LW-1:0]   t_line;

  always_comb begin
    phase   = nxt_h[CWL-1:0];
    in_line = (phase == '0) &&
              (({1'b0, nxt_h} + (HW+1)'(CELL_W)) < (HW+1)'(ACT_W));
    wrap    = (nxt_h == HW'(H_TOTAL-CELL_W));
    if (in_line) begin
      tgt_v     = nxt_v;
      tgt_crow  = nxt_crow;
      tgt_cline = nxt_cline;
      tgt_col   = COLW'(32'(nxt_h >> CWL) + 1);
    end else begin
      tgt_v     = fol_v;
      tgt_crow  = fol_crow;
      tgt_cline = fol_cline;
      tgt_col   = '0;
    end
    tgt_act = (tgt_v < VW'(ACT_H));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scr_addr <= '0;
      gly_addr <= '0;
      t_ok     <= 1'b0;
      t_line   <= '0;
    end else if (adv) begin
      if (in_line || wrap) begin
        t_ok   <= tgt_act;
        t_line <= tgt_cline;
        if (tgt_act)
          scr_addr <= SCR_AW'(32'(tgt_crow) * COLS + 32'(tgt_col));
      end
      if (phase == CWL'(CELL_W/2) && t_ok)
        gly_addr <= {scr_code, t_line};
    end
  end
endmodule

// File: rtl/vt_shift.sv
`timescale 1ns/1ps
// Glyph slice serializer, most significant bit first.
module vt_shift #(
  parameter int CELL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              load,
  input  logic [CELL_W-1:0] gly_data,
  output logic              msb
);
  logic [CELL_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)
      sr <= '0;
    else if (adv)
      sr <= load ? gly_data : {sr[CELL_W-2:0], 1'b0};
  end

  assign msb = sr[CELL_W-1];
endmodule

// File: rtl/text_cell_video.sv
`timescale 1ns/1ps
module text_cell_video #(
  parameter int ACT_W    = 256,
  parameter int ACT_H    = 192,
  parameter int CELL_W   = 8,
  parameter int CELL_H   = 12,
  parameter int CODE_W   = 7,
  parameter int H_TOTAL  = 320,
  parameter int V_TOTAL  = 262,
  parameter int HS_START = 272,
  parameter int HS_END   = 296,
  parameter int VS_START = 216,
  parameter int VS_END   = 219,
  localparam int COLS    = ACT_W / CELL_W,
  localparam int ROWS    = ACT_H / CELL_H,
  localparam int SCR_AW  = $clog2(COLS * ROWS),
  localparam int LW      = $clog2(CELL_H),
  localparam int GLY_AW  = CODE_W + LW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_ready,
  output logic              pix_valid,
  output logic              pix_data,
  output logic              pix_active,
  output logic              pix_hsync,
  output logic              pix_vsync,
  output logic [SCR_AW-1:0] scr_addr,
  input  logic [CODE_W-1:0] scr_code,
  output logic [GLY_AW-1:0] gly_addr,
  input  logic [CELL_W-1:0] gly_data
);
  import vt_pkg::*;

  localparam int HW   = $clog2(H_TOTAL);
  localparam int VW   = $clog2(V_TOTAL);
  localparam int RW   = $clog2(V_TOTAL / CELL_H + 1);
  localparam int CWL  = $clog2(CELL_W);
  localparam int COLW = $clog2(COLS);

  logic          adv, load, msb;
  logic [HW-1:0] h, nxt_h;
  logic [VW-1:0] v, nxt_v, fol_v;
  logic [RW-1:0] nxt_crow, fol_crow;
  logic [LW-1:0] nxt_cline, fol_cline;
  vt_flags_t     fl;

  always_ff @(posedge clk) begin
    if (!rst_n) pix_valid <= 1'b0;
    else        pix_valid <= 1'b1;
  end

  assign adv = pix_valid & pix_ready;

  vt_raster #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .CELL_H(CELL_H),
    .HW(HW), .VW(VW), .RW(RW), .LW(LW)
  ) raster_i (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .h(h), .v(v),
    .nxt_h(nxt_h), .nxt_v(nxt_v), .nxt_crow(nxt_crow), .nxt_cline(nxt_cline),
    .fol_v(fol_v), .fol_crow(fol_crow), .fol_cline(fol_cline)
  );

  vt_fetch #(
    .ACT_W(ACT_W), .ACT_H(ACT_H), .CELL_W(CELL_W), .H_TOTAL(H_TOTAL),
    .HW(HW), .VW(VW), .RW(RW), .LW(LW), .CODE_W(CODE_W),
    .SCR_AW(SCR_AW), .COLS(COLS), .COLW(COLW)
  ) fetch_i (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .nxt_h(nxt_h), .nxt_v(nxt_v), .nxt_crow(nxt_crow), .nxt_cline(nxt_cline),
    .fol_v(fol_v), .fol_crow(fol_crow), .fol_cline(fol_cline),
    .scr_code(scr_code), .scr_addr(scr_addr), .gly_addr(gly_addr)
  );

  // The slice for a cell is taken as the raster steps onto that cell's first pixel.
  assign load = (nxt_h[CWL-1:0] == '0) && (nxt_h < HW'(ACT_W)) && (nxt_v < VW'(ACT_H));

  vt_shift #(.CELL_W(CELL_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .load(load),
    .gly_data(gly_data), .msb(msb)
  );

  always_comb begin
    fl.act = (h < HW'(ACT_W)) && (v < VW'(ACT_H));
    fl.hs  = (h >= HW'(HS_START)) && (h < HW'(HS_END));
    fl.vs  = (v >= VW'(VS_START)) && (v < VW'(VS_END));
  end

  assign pix_active = pix_valid & fl.act;
  assign pix_data   = pix_valid & fl.act & msb;
  assign pix_hsync  = pix_valid & fl.hs;
  assign pix_vsync  = pix_valid & fl.vs;
endmodule

// File: rtl/vt_chk.sv
`timescale 1ns/1ps
module vt_chk #(
  parameter int SCR_AW = 9,
  parameter int GLY_AW = 11,
  parameter int LW     = 4,
  parameter int CELL_H = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_ready,
  input logic              pix_valid,
  input logic              pix_data,
  input logic              pix_active,
  input logic              pix_hsync,
  input logic              pix_vsync,
  input logic [SCR_AW-1:0] scr_addr,
  input logic [GLY_AW-1:0] gly_addr
);
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data) && $stable(pix_active)
                                   && $stable(pix_hsync) && $stable(pix_vsync)));

  assert_valid_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> pix_valid);

  assert_black_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_active |-> !pix_data);

  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_valid && pix_ready) |=> ($stable(scr_addr) && $stable(gly_addr)));

  assert_line_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gly_addr[LW-1:0]) < CELL_H);

  assert_sync_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_hsync || pix_vsync) |-> !pix_active);
endmodule

bind text_cell_video vt_chk #(
  .SCR_AW(SCR_AW), .GLY_AW(GLY_AW), .LW(LW), .CELL_H(CELL_H)
) chk_i (
  .clk(clk), .rst_n(rst_n), .pix_ready(pix_ready), .pix_valid(pix_valid),
  .pix_data(pix_data), .pix_active(pix_active), .pix_hsync(pix_hsync),
  .pix_vsync(pix_vsync), .scr_addr(scr_addr), .gly_addr(gly_addr)
);

// File: tb/text_cell_video_tb_top.sv
`timescale 1ns/1ps
module text_cell_video_tb_top;
  localparam int H = 320, V = 262;
  localparam int HS0 = 272, HS1 = 296, VS0 = 216, VS1 = 219;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_ready = 1'b0;
  logic       pix_valid, pix_data, pix_active, pix_hsync, pix_vsync;
  logic [8:0] scr_addr;
  logic [6:0] scr_code;
  logic [10:0] gly_addr;
  logic [7:0] gly_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  text_cell_video #(
    .H_TOTAL(H), .V_TOTAL(V), .HS_START(HS0), .HS_END(HS1),
    .VS_START(VS0), .VS_END(VS1)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pix_ready(pix_ready), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_active(pix_active), .pix_hsync(pix_hsync),
    .pix_vsync(pix_vsync), .scr_addr(scr_addr), .scr_code(scr_code),
    .gly_addr(gly_addr), .gly_data(gly_data)
  );

  // Screen contents and glyph patterns, computed.
  function automatic int code_of(int a);
    return (a * 37 + (a / 32) * 11 + 5) % 128;
  endfunction
  function automatic int glyph_of(int c, int ln);
    return (c * 29 + ln * 71 + c * ln + 13) % 256;
  endfunction

  // Synchronous memories with one clock of read latency.
  always @(posedge clk) begin
    scr_code <= 7'(code_of(int'(scr_addr)));
    gly_data <= 8'(glyph_of(int'(gly_addr[10:4]), int'(gly_addr[3:0])));
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Reference model for beat k: position computed with division and modulo.
  localparam int START = (V - 1) * H;
  function automatic int exp_bit(int k, int sel);
    int pos, hh, vv, g;
    bit act;
    pos = START + k;
    hh  = pos % H;
    vv  = (pos / H) % V;
    act = (hh < 256) && (vv < 192);
    case (sel)
      0: begin
        if (!act) return 0;
        g = glyph_of(code_of((vv / 12) * 32 + hh / 8), vv % 12);
        return (g >> (7 - hh % 8)) & 1;
      end
      1: return int'(act);
      2: return int'(hh >= HS0 && hh < HS1);
      default: return int'(vv >= VS0 && vv < VS1);
    endcase
  endfunction

  initial begin
    int  k = 0;
    int  cyc = 0;
    int  long_stall = 0;
    bit  long_done = 0;
    bit  prev_stall = 0, prev_hs = 0, have_prev = 0;
    bit  have_chg = 0;
    int  last_chg_k = 0;
    logic [3:0]  prev_out;
    logic [8:0]  prev_scr;
    logic [10:0] prev_gly;
    int  end_k = V * H + 3 * H;

    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(pix_valid == 1'b0, "R1 valid in reset", int'(pix_valid), 0);
      chk(pix_data == 1'b0 && pix_active == 1'b0, "R1 black in reset",
          int'({pix_active, pix_data}), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(pix_valid == 1'b1, "R1 valid after reset", int'(pix_valid), 1);
    chk(pix_active == 1'b0 && pix_data == 1'b0, "R1 first beat blank",
        int'({pix_active, pix_data}), 0);

    while (k < end_k) begin
      string tag;
      // Compare the beat on offer with the model.
      tag = ((START + k) / H >= 2 * V) ? "R10 R2 R4 R5 R6 pixel" : "R2 R4 R5 R6 pixel";
      chk(pix_valid == 1'b1, "R8 valid stays high", int'(pix_valid), 1);
      chk(int'(pix_active) == exp_bit(k, 1), "R3 active flag", int'(pix_active), exp_bit(k, 1));
      chk(int'(pix_hsync) == exp_bit(k, 2), "R9 hsync", int'(pix_hsync), exp_bit(k, 2));
      chk(int'(pix_vsync) == exp_bit(k, 3), "R9 vsync", int'(pix_vsync), exp_bit(k, 3));
      chk(int'(pix_data) == exp_bit(k, 0), tag, int'(pix_data), exp_bit(k, 0));
      if (!pix_active)
        chk(pix_data == 1'b0, "R3 black outside area", int'(pix_data), 0);

      if (have_prev && prev_stall)
        chk({pix_data, pix_active, pix_hsync, pix_vsync} == prev_out, "R8 held under stall",
            int'({pix_data, pix_active, pix_hsync, pix_vsync}), int'(prev_out));
      if (have_prev && !prev_hs) begin
        chk(scr_addr == prev_scr, "R7 screen address held", int'(scr_addr), int'(prev_scr));
        chk(gly_addr == prev_gly, "R7 glyph address held", int'(gly_addr), int'(prev_gly));
      end
      if (have_prev && scr_addr != prev_scr) begin
        if (have_chg)
          chk(k - last_chg_k >= 8, "R7 screen address rate", k - last_chg_k, 8);
        have_chg = 1;
        last_chg_k = k;
      end

      // Choose ready for the coming edge.
      if (!long_done && k == 5003 && long_stall == 0) long_stall = 40;
      if (long_stall > 0) begin
        pix_ready = 1'b0;
        long_stall--;
        if (long_stall == 0) long_done = 1;
      end else if (k < 2 * H)
        pix_ready = 1'b1;
      else if (k < 120 * H)
        pix_ready = ($urandom % 4) != 0;
      else
        pix_ready = (cyc % 3) != 0;

      prev_out   = {pix_data, pix_active, pix_hsync, pix_vsync};
      prev_scr   = scr_addr;
      prev_gly   = gly_addr;
      prev_stall = pix_valid && !pix_ready;
      prev_hs    = pix_valid && pix_ready;
      have_prev  = 1;
      if (pix_valid && pix_ready) k++;
      cyc++;
      @(negedge clk);
    end
    wrap_up();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      wrap_up();
    end
  end
endmodule